// File: doc/BRIEF.md
# Ternary Lookup Table with Learn

A small register-based lookup table of 72-bit entries driven from a single command bus. A host can read and write individual entries and global mask registers, search every occupied entry at once for a key under a selectable global mask, and ask the table to store a new key in the first free slot. Bit 0 of every entry is its occupancy marker (0 free, 1 taken). A search ignores bit 0 of the key and never matches a free slot. A learn sets bit 0 itself. A status flag goes high once no free slot is left.

Each command is presented on `cmd` together with `cmdValid` and the 72-bit operand on `keyData`. All results are registered and appear one clock after the command. The `cfgExt` input selects the command set. When it is low (compatibility mode), command bits 10 and 9 are ignored and 8 global masks are reachable. When it is high, those two bits are decoded and all 16 masks are reachable. Command fields: bits [1:0] are the opcode (00 read, 01 write, 10 search, 11 learn). Bits [5:2] are the entry index. Bits [4:2] are the low three bits of the mask index. Bit 6 selects the mask bank instead of the entry array for reads and writes. Bit 9 is mask index bit 3. Bit 10 on an entry write also copies the operand into the selected mask register. A mask bit set to 1 removes that key bit from the comparison.

Top module: `tern_learn_table`

## Requirements
- R1: After `rstN` is low, all entries and masks read back as zero, and `fullFlag`, `rdValid`, `srchDone`, `srchHit` and `learnErr` are 0.
- R2: In a cycle with `cmdValid` = 0, no command is executed: no table or mask change, and no result strobe in the next cycle.
- R3: A read (opcode 00, bit 6 = 0) returns the addressed entry on `rdData`, with `rdValid` high, exactly one cycle after the command. A write (opcode 01, bit 6 = 0) stores `keyData`, including bit 0, into the entry given by bits [5:2].
- R4: A search (opcode 10) raises `srchDone` one cycle later. If any occupied entry equals the key on bits [71:1] at every position where the selected mask is 0, `srchHit` is 1 and `srchIdx` is the lowest such index.
- R5: An entry whose bit 0 is 0 never matches a search, whatever its other bits hold.
- R6: A learn (opcode 11) writes `keyData` with bit 0 forced to 1 into the lowest-index free entry.
- R7: A learn issued when no entry is free changes nothing and pulses `learnErr` for one cycle. `fullFlag` is high in that same cycle.
- R8: `fullFlag` follows the AND of all occupancy bits with one cycle of lag: it rises one cycle after the last free slot is taken and falls one cycle after any slot is freed.
- R9: With `cfgExt` = 0, command bits 10 and 9 have no effect. The mask index is bits [4:2] only, and an entry write never touches a mask.
- R10: With `cfgExt` = 1, bit 9 is mask index bit 3, giving 16 masks that are separately addressable for read, write and search.
- R11: With `cfgExt` = 1, an entry write with bit 10 set also stores `keyData` into the mask register selected by {bit 9, bits [4:2]}.
- R12: A read or write with bit 6 = 1 accesses the selected mask register instead of an entry, with the same one-cycle read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Qualifies `cmd` for this cycle |
| cmd | input | 11 | Opcode and parameter fields |
| cfgExt | input | 1 | 1 = extended command set, 0 = compatibility mode |
| keyData | input | 72 | Write data, search key or learn key |
| rdData | output | 72 | Read result, valid with `rdValid` |
| rdValid | output | 1 | Read result strobe |
| srchDone | output | 1 | Search result strobe |
| srchHit | output | 1 | Search found a match |
| srchIdx | output | 4 | Lowest matching entry index |
| learnErr | output | 1 | Learn rejected because the table is full |
| fullFlag | output | 1 | All entries occupied |

## Verification
The assertions assume that `cmdValid` is low while reset is held and in the first cycle after it. They also assume that `cmd`, `cfgExt` and `keyData` change only away from the rising edge. The bench meets both conditions: it holds `cmdValid` at 0 through reset and changes every input on the falling edge. The learn-error assertion relies on the flag lag described in R8. A rejected learn can only occur once every slot has been occupied for at least one edge, so `fullFlag` is already high in the cycle `learnErr` pulses. The stimulus reaches that state only through a run of successful learns.

// File: rtl/tlt_pkg.sv
package tlt_pkg;
  localparam int DATA_W       = 72;
  localparam int DEPTH        = 16;
  localparam int NUM_MASK     = 16;
  localparam int COMPAT_MASKS = 8;
  localparam int CMD_W        = 11;
  localparam int IDX_W        = $clog2(DEPTH);
  localparam int MIDX_W       = $clog2(NUM_MASK);
  localparam int CMIDX_W      = $clog2(COMPAT_MASKS);

  // command field positions
  localparam int F_IDX_LO = 2;
  localparam int F_TGT    = 6;
  localparam int F_MHI    = 9;
  localparam int F_PAR    = 10;

  typedef enum logic [1:0] {
    OP_RD    = 2'b00,
    OP_WR    = 2'b01,
    OP_SRCH  = 2'b10,
    OP_LEARN = 2'b11
  } op_e;

  typedef struct packed {
    logic              rdEntry;
    logic              rdMask;
    logic              wrEntry;
    logic              wrMask;
    logic              search;
    logic              learn;
    logic [IDX_W-1:0]  entryIdx;
    logic [MIDX_W-1:0] maskIdx;
  } strobe_t;
endpackage

// File: rtl/tlt_ctrl.sv
module tlt_ctrl
  import tlt_pkg::*;
(
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmd,
  input  logic             cfgExt,
  output strobe_t          st
);
  op_e  op;
  logic toMask;
  logic maskHi;
  logic parWr;

  always_comb begin
    op     = op_e'(cmd[1:0]);
    toMask = cmd[F_TGT];
    maskHi = cfgExt & cmd[F_MHI];
    parWr  = cfgExt & cmd[F_PAR];
    st          = '0;
    st.entryIdx = cmd[F_IDX_LO +: IDX_W];
    st.maskIdx  = MIDX_W'(cmd[F_IDX_LO +: CMIDX_W]) |
                  (maskHi ? MIDX_W'(COMPAT_MASKS) : MIDX_W'(0));
    if (cmdValid) begin
      case (op)
        OP_RD: begin
          st.rdMask  = toMask;
          st.rdEntry = !toMask;
        end
        OP_WR: begin
          st.wrEntry = !toMask;
          st.wrMask  = toMask | parWr;
        end
        OP_SRCH:  st.search = 1'b1;
        OP_LEARN: st.learn  = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/tlt_data.sv
module tlt_data
  import tlt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] key,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              srchDone,
  output logic              srchHit,
  output logic [IDX_W-1:0]  srchIdx,
  output logic              learnErr,
  output logic              fullFlag
);
  logic [DATA_W-1:0] entries [DEPTH];
  logic [DATA_W-1:0] masks   [NUM_MASK];
  logic [DATA_W-1:0] maskSel;
  logic [DEPTH-1:0]  occ;
  logic [DEPTH-1:0]  match;
  logic              anyMatch, anyFree;
  logic [IDX_W-1:0]  matchIdx, freeIdx;

  assign maskSel = masks[st.maskIdx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [DATA_W-1:0] diff;
    assign diff     = (entries[g] ^ key) & ~maskSel;
    assign occ[g]   = entries[g][0];
    assign match[g] = occ[g] && (diff[DATA_W-1:1] == '0);
  end

  // lowest-index pickers for matches and free slots
  always_comb begin
    anyMatch = 1'b0;
    matchIdx = '0;
    anyFree  = 1'b0;
    freeIdx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        anyMatch = 1'b1;
        matchIdx = IDX_W'(i);
      end
      if (!occ[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) entries[i] <= '0;
      for (int i = 0; i < NUM_MASK; i++) masks[i] <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
      srchDone <= 1'b0;
      srchHit  <= 1'b0;
      srchIdx  <= '0;
      learnErr <= 1'b0;
      fullFlag <= 1'b0;
    end else begin
      rdValid  <= st.rdEntry | st.rdMask;
      if (st.rdEntry)     rdData <= entries[st.entryIdx];
      else if (st.rdMask) rdData <= masks[st.maskIdx];
      srchDone <= st.search;
      srchHit  <= st.search & anyMatch;
      if (st.search) srchIdx <= anyMatch ? matchIdx : '0;
      learnErr <= st.learn & !anyFree;
      fullFlag <= &occ;
      if (st.wrEntry) entries[st.entryIdx] <= key;
      if (st.wrMask)  masks[st.maskIdx]    <= key;
      if (st.learn && anyFree) entries[freeIdx] <= {key[DATA_W-1:1], 1'b1};
    end
  end
endmodule

// File: rtl/tern_learn_table.sv
module tern_learn_table
  import tlt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              cfgExt,
  input  logic [DATA_W-1:0] keyData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              srchDone,
  output logic              srchHit,
  output logic [IDX_W-1:0]  srchIdx,
  output logic              learnErr,
  output logic              fullFlag
);
  strobe_t st;

  tlt_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmd      (cmd),
    .cfgExt   (cfgExt),
    .st       (st)
  );

  tlt_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .key      (keyData),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .srchDone (srchDone),
    .srchHit  (srchHit),
    .srchIdx  (srchIdx),
    .learnErr (learnErr),
    .fullFlag (fullFlag)
  );
endmodule

// File: rtl/tern_learn_table_chk.sv
module tern_learn_table_chk
  import tlt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [CMD_W-1:0] cmd,
  input logic             rdValid,
  input logic             srchDone,
  input logic             srchHit,
  input logic             learnErr,
  input logic             fullFlag
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !(rdValid || srchDone || learnErr));

  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmd[1:0] == 2'b00) |=> rdValid);

  a_r4_search_latency: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmd[1:0] == 2'b10) |=> srchDone);

  a_r4_hit_with_done: assert property (@(posedge clk) disable iff (!rstN)
    srchHit |-> srchDone);

  a_r7_err_after_learn: assert property (@(posedge clk) disable iff (!rstN)
    learnErr |-> $past(cmdValid && cmd[1:0] == 2'b11));

  a_r7_err_while_full: assert property (@(posedge clk) disable iff (!rstN)
    learnErr |-> fullFlag);
endmodule

bind tern_learn_table tern_learn_table_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmd      (cmd),
  .rdValid  (rdValid),
  .srchDone (srchDone),
  .srchHit  (srchHit),
  .learnErr (learnErr),
  .fullFlag (fullFlag)
);

// File: tb/tern_learn_table_tb.sv
module tern_learn_table_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        vld;
    logic        cfg;
    logic [10:0] cmd;
    logic [71:0] din;
    logic [71:0] expRd;
    logic        expHit;
    logic [3:0]  expIdx;
  } vec_t;

  function automatic logic [10:0] mk(input logic [1:0] op, input logic [3:0] idx,
                                     input logic tgt, input logic b9, input logic b10);
    return {b10, b9, 2'b00, tgt, idx, op};
  endfunction

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, SR = 2'b10, LN = 2'b11;
  localparam logic [71:0] K_A    = 72'h5A_0000_0000_0000_0A01;
  localparam logic [71:0] K_A0   = 72'h5A_0000_0000_0000_0A00;
  localparam logic [71:0] K_B    = 72'h5A_0000_0000_0000_0B01;
  localparam logic [71:0] M_NIB  = 72'h00_0000_0000_0000_0F00;
  localparam logic [71:0] M_WIDE = 72'h00_0000_0000_0000_FF00;
  localparam logic [71:0] K_C    = 72'h3C_0000_0000_0000_0C00;
  localparam logic [71:0] K_C1   = 72'h3C_0000_0000_0000_0C01;
  localparam logic [71:0] K_D    = 72'h4D_0000_0000_0000_0D01;
  localparam logic [71:0] K_E    = 72'h4E_0000_0000_0000_0E01;
  localparam logic [71:0] Z      = 72'h0;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, mk(RD,4'd3,1'b0,1'b0,1'b0), Z,     Z,      1'b0, 4'd0}, // R2 idle
    '{1'b1, 1'b1, mk(WR,4'd3,1'b0,1'b0,1'b0), K_A,   Z,      1'b0, 4'd0}, // R3 write
    '{1'b1, 1'b1, mk(RD,4'd3,1'b0,1'b0,1'b0), Z,     K_A,    1'b0, 4'd0}, // R3 read
    '{1'b1, 1'b1, mk(WR,4'd5,1'b0,1'b0,1'b0), K_A,   Z,      1'b0, 4'd0},
    '{1'b1, 1'b1, mk(SR,4'd0,1'b0,1'b0,1'b0), K_A,   Z,      1'b1, 4'd3}, // R4 lowest
    '{1'b1, 1'b1, mk(WR,4'd3,1'b0,1'b0,1'b0), K_A0,  Z,      1'b0, 4'd0}, // R5 free it
    '{1'b1, 1'b1, mk(SR,4'd0,1'b0,1'b0,1'b0), K_A,   Z,      1'b1, 4'd5}, // R5 skip free
    '{1'b1, 1'b1, mk(SR,4'd0,1'b0,1'b0,1'b0), K_B,   Z,      1'b0, 4'd0}, // R4 miss
    '{1'b1, 1'b1, mk(WR,4'd2,1'b1,1'b0,1'b0), M_NIB, Z,      1'b0, 4'd0}, // R12 mask wr
    '{1'b1, 1'b1, mk(RD,4'd2,1'b1,1'b0,1'b0), Z,     M_NIB,  1'b0, 4'd0}, // R12 mask rd
    '{1'b1, 1'b1, mk(SR,4'd2,1'b0,1'b0,1'b0), K_B,   Z,      1'b1, 4'd5}, // R4 masked
    '{1'b1, 1'b0, mk(SR,4'd2,1'b0,1'b1,1'b1), K_B,   Z,      1'b1, 4'd5}, // R9 bit9 ignored
    '{1'b1, 1'b1, mk(SR,4'd2,1'b0,1'b1,1'b0), K_B,   Z,      1'b0, 4'd0}, // R10 mask 10
    '{1'b1, 1'b1, mk(WR,4'd2,1'b1,1'b1,1'b0), M_WIDE,Z,      1'b0, 4'd0}, // R10 wr mask 10
    '{1'b1, 1'b1, mk(RD,4'd2,1'b1,1'b1,1'b0), Z,     M_WIDE, 1'b0, 4'd0}, // R10 rd mask 10
    '{1'b1, 1'b0, mk(RD,4'd2,1'b1,1'b1,1'b0), Z,     M_NIB,  1'b0, 4'd0}, // R9 rd mask 2
    '{1'b1, 1'b1, mk(LN,4'd0,1'b0,1'b0,1'b0), K_C,   Z,      1'b0, 4'd0}, // R6 learn
    '{1'b1, 1'b1, mk(RD,4'd0,1'b0,1'b0,1'b0), Z,     K_C1,   1'b0, 4'd0}, // R6 slot 0
    '{1'b1, 1'b1, mk(WR,4'd1,1'b0,1'b1,1'b1), K_D,   Z,      1'b0, 4'd0}, // R11 parallel
    '{1'b1, 1'b1, mk(RD,4'd1,1'b1,1'b1,1'b0), Z,     K_D,    1'b0, 4'd0}, // R11 mask 9
    '{1'b1, 1'b0, mk(WR,4'd2,1'b0,1'b0,1'b1), K_E,   Z,      1'b0, 4'd0}, // R9 no parallel
    '{1'b1, 1'b1, mk(RD,4'd2,1'b1,1'b0,1'b0), Z,     M_NIB,  1'b0, 4'd0}, // R9 mask 2 kept
    '{1'b1, 1'b1, mk(RD,4'd2,1'b0,1'b0,1'b0), Z,     K_E,    1'b0, 4'd0}, // R9 entry 2
    '{1'b0, 1'b1, mk(WR,4'd6,1'b0,1'b0,1'b0), K_B,   Z,      1'b0, 4'd0}, // R2 dropped write
    '{1'b1, 1'b1, mk(SR,4'd0,1'b0,1'b0,1'b0), K_B,   Z,      1'b0, 4'd0}  // R2 nothing stored
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [10:0] cmd;
  logic        cfgExt;
  logic [71:0] keyData;
  logic [71:0] rdData;
  logic        rdValid, srchDone, srchHit, learnErr, fullFlag;
  logic [3:0]  srchIdx;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tern_learn_table u_dut (
    .clk (clk), .rstN (rstN), .cmdValid (cmdValid), .cmd (cmd), .cfgExt (cfgExt),
    .keyData (keyData), .rdData (rdData), .rdValid (rdValid), .srchDone (srchDone),
    .srchHit (srchHit), .srchIdx (srchIdx), .learnErr (learnErr), .fullFlag (fullFlag)
  );

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the next rising edge
  task automatic apply(input logic v, input logic cfg, input logic [10:0] c, input logic [71:0] d);
    cmdValid = v;
    cfgExt   = cfg;
    cmd      = c;
    keyData  = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmd = '0; cfgExt = 1'b1; keyData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset strobes", {67'd0, rdValid, srchDone, srchHit, learnErr, fullFlag}, Z);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic isRd, isSr;
      apply(VECS[v].vld, VECS[v].cfg, VECS[v].cmd, VECS[v].din);
      isRd = VECS[v].vld && VECS[v].cmd[1:0] == RD;
      isSr = VECS[v].vld && VECS[v].cmd[1:0] == SR;
      chk($sformatf("R3 rdValid vec %0d", v), 72'(rdValid), 72'(isRd));
      if (isRd) chk($sformatf("R3 rdData vec %0d", v), rdData, VECS[v].expRd);
      chk($sformatf("R4 srchDone vec %0d", v), 72'(srchDone), 72'(isSr));
      if (isSr) begin
        chk($sformatf("R4 srchHit vec %0d", v), 72'(srchHit), 72'(VECS[v].expHit));
        if (VECS[v].expHit) chk($sformatf("R4 srchIdx vec %0d", v), 72'(srchIdx), 72'(VECS[v].expIdx));
      end
      chk($sformatf("R7 learnErr vec %0d", v), 72'(learnErr), Z);
      chk($sformatf("R8 fullFlag vec %0d", v), 72'(fullFlag), Z);
    end

    // R6: fill the 12 free slots (3,4,6..15) in index order
    for (int i = 0; i < 12; i++) begin
      apply(1'b1, 1'b1, mk(LN, 4'd0, 1'b0, 1'b0, 1'b0), 72'h33_0000_0000_0000_0000 | (72'(i) << 8));
      chk($sformatf("R6 learn %0d no error", i), 72'(learnErr), Z);
      chk($sformatf("R8 flag lag learn %0d", i), 72'(fullFlag), Z);
    end
    // R7 and R8: table now full
    apply(1'b1, 1'b1, mk(LN, 4'd0, 1'b0, 1'b0, 1'b0), 72'h77_0000_0000_0000_0000);
    chk("R7 learn rejected pulse", 72'(learnErr), 72'd1);
    chk("R8 full after last slot", 72'(fullFlag), 72'd1);
    apply(1'b1, 1'b1, mk(SR, 4'd0, 1'b0, 1'b0, 1'b0), 72'h77_0000_0000_0000_0001);
    chk("R7 error one cycle", 72'(learnErr), Z);
    chk("R7 rejected key not stored", 72'(srchHit), Z);
    apply(1'b1, 1'b1, mk(RD, 4'd3, 1'b0, 1'b0, 1'b0), Z);
    chk("R6 first learned in slot 3", rdData, 72'h33_0000_0000_0000_0001);
    apply(1'b1, 1'b1, mk(RD, 4'd6, 1'b0, 1'b0, 1'b0), Z);
    chk("R6 third learned in slot 6", rdData, 72'h33_0000_0000_0000_0201);
    apply(1'b1, 1'b1, mk(RD, 4'd15, 1'b0, 1'b0, 1'b0), Z);
    chk("R6 last learned in slot 15", rdData, 72'h33_0000_0000_0000_0B01);
    apply(1'b1, 1'b1, mk(SR, 4'd0, 1'b0, 1'b0, 1'b0), 72'h33_0000_0000_0000_0401);
    chk("R4 hit on learned key", 72'(srchIdx), 72'd8);

    // R8: free slot 7, flag falls one cycle later
    apply(1'b1, 1'b1, mk(WR, 4'd7, 1'b0, 1'b0, 1'b0), Z);
    chk("R8 flag still high", 72'(fullFlag), 72'd1);
    apply(1'b0, 1'b1, '0, Z);
    chk("R8 flag falls", 72'(fullFlag), Z);
    apply(1'b1, 1'b1, mk(LN, 4'd0, 1'b0, 1'b0, 1'b0), 72'h99_0000_0000_0000_0000);
    chk("R7 learn accepted again", 72'(learnErr), Z);
    apply(1'b1, 1'b1, mk(RD, 4'd7, 1'b0, 1'b0, 1'b0), Z);
    chk("R6 learn fills freed slot", rdData, 72'h99_0000_0000_0000_0001);

    // R1: reset mid-run clears everything
    rstN = 1'b0;
    apply(1'b0, 1'b1, '0, Z);
    apply(1'b0, 1'b1, '0, Z);
    chk("R1 full cleared", 72'(fullFlag), Z);
    rstN = 1'b1;
    apply(1'b0, 1'b1, '0, Z);
    apply(1'b1, 1'b1, mk(RD, 4'd5, 1'b0, 1'b0, 1'b0), Z);
    chk("R1 entry cleared", rdData, Z);
    apply(1'b1, 1'b1, mk(RD, 4'd2, 1'b1, 1'b0, 1'b0), Z);
    chk("R1 mask cleared", rdData, Z);
    apply(1'b1, 1'b1, mk(SR, 4'd0, 1'b0, 1'b0, 1'b0), Z);
    chk("R1 no occupied entry", 72'(srchHit), Z);

    summary();
    $finish;
  end
endmodule